// File: doc/BRIEF.md
# Pipeline Trap Priority Arbiter

This block decides, once per clock, which trap (if any) a five-stage in-order RV32 core takes. Each stage that can fault (fetch, decode, execute, memory) presents a valid bit, a set of exception flags and its PC. The block also receives the machine interrupt pending and enable bits and the global interrupt enable. It returns one registered trap pulse with the cause code, the index of the stage being trapped, that stage's PC, and a flush mask. The mask covers the trapped stage and every younger stage.

Ordering follows the age of the instructions. The oldest valid stage that carries an exception wins, and a fixed cause order applies inside a stage. A gated machine interrupt beats any exception and is attached to the oldest valid instruction, so a later memory fault cannot overtake it. No trap is accepted while a data-bus access is outstanding. The cycle right after a trap is also a holdoff cycle, so that the flush can take effect before the next decision.

Top module: `trap_arbiter`

## Requirements
- R1: After reset, and in every cycle that carries no trap, trap_valid is 0 and trap_cause, trap_stage, trap_pc and trap_flush are all zero.
- R2: When mem_busy is 1 in a cycle, the output registered at the next edge shows no trap, whatever the other inputs are.
- R3: A machine interrupt source counts only when its bit in irq_pend, its bit in irq_en and glb_ie are all 1. Bit 0 is software, bit 1 is timer and bit 2 is external.
- R4: Among the gated interrupt sources, external ranks first, then software, then timer. The cause is {1'b1, zeros, code}, with codes 11 (external), 3 (software) and 7 (timer).
- R5: A gated interrupt takes precedence over every exception. It is reported at the highest-numbered valid stage, or at stage 0 when no stage is valid, together with that stage's PC.
- R6: When several valid stages raise exceptions, the highest-numbered stage is chosen. Stage index 0 is fetch and the youngest; NSTG-1 is memory and the oldest.
- R7: Within a stage the flag slots rank 0 first: slot 0 illegal instruction (code 2), 1 instruction address misaligned (0), 2 ecall (11), 3 ebreak (3), 4 load misaligned (4), 5 load fault (5), 6 store misaligned (6), 7 store fault (7). Stage s owns bits [8s+7:8s] of stg_exc. An exception cause has bit 31 clear.
- R8: With a trap, trap_flush bit s is 1 exactly for s <= trap_stage.
- R9: Exception flags of a stage whose stg_vld bit is 0 have no effect on the outputs.
- R10: Outputs are registered, so inputs of one cycle appear after the next rising edge. No trap is produced in the cycle that directly follows a trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stg_vld | input | NSTG | Per-stage instruction valid |
| stg_exc | input | NSTG*8 | Per-stage exception flags, 8 slots per stage |
| stg_pc | input | NSTG*XLEN | Per-stage PC, stage s at [XLEN*s +: XLEN] |
| irq_pend | input | 3 | Interrupt pending {external, timer, software} |
| irq_en | input | 3 | Interrupt enable, same bit order |
| glb_ie | input | 1 | Global machine interrupt enable |
| mem_busy | input | 1 | Data-bus access outstanding |
| trap_valid | output | 1 | One-cycle trap pulse |
| trap_cause | output | XLEN | Cause code, bit XLEN-1 marks an interrupt |
| trap_stage | output | $clog2(NSTG) | Index of the trapped stage |
| trap_pc | output | XLEN | PC of the trapped stage |
| trap_flush | output | NSTG | Flush request per stage |

## Verification
The assertions assume that mem_busy, the flags and the interrupt bits are steady around the rising edge. They also assume that the core lowers its sources once it has seen a flush, although a source that stays raised only produces a pulse every other cycle. The random stimulus changes the inputs only on the falling edge. It keeps the exception flags sparse, so that both single-flag and multi-flag stages occur. It raises mem_busy about one cycle in five, so that the blocked and unblocked paths both get exercised.

// File: rtl/trap_arb_pkg.sv
// Package: shared constants and cause-code mapping for the trap arbiter.
// Assumes slot order inside a stage is the priority order (slot 0 highest).
package trap_arb_pkg;
    localparam int NCAUSE = 8;
    localparam int NIRQ   = 3;

    typedef enum logic [2:0] {
        SLOT_ILLEGAL = 3'd0,
        SLOT_IMISAL  = 3'd1,
        SLOT_ECALL   = 3'd2,
        SLOT_EBREAK  = 3'd3,
        SLOT_LMISAL  = 3'd4,
        SLOT_LFAULT  = 3'd5,
        SLOT_SMISAL  = 3'd6,
        SLOT_SFAULT  = 3'd7
    } exc_slot_e;

    // Interrupt bit positions on irq_pend / irq_en
    localparam int IRQ_SW  = 0;
    localparam int IRQ_TMR = 1;
    localparam int IRQ_EXT = 2;

    // Map an exception slot to its standard exception code
    function automatic logic [4:0] exc_code(input logic [2:0] slot);
        case (exc_slot_e'(slot))
            SLOT_ILLEGAL: exc_code = 5'd2;
            SLOT_IMISAL:  exc_code = 5'd0;
            SLOT_ECALL:   exc_code = 5'd11;
            SLOT_EBREAK:  exc_code = 5'd3;
            SLOT_LMISAL:  exc_code = 5'd4;
            SLOT_LFAULT:  exc_code = 5'd5;
            SLOT_SMISAL:  exc_code = 5'd6;
            default:      exc_code = 5'd7;
        endcase
    endfunction

    // Map an interrupt rank (0 external, 1 software, 2 timer) to its code
    function automatic logic [4:0] irq_code(input logic [1:0] rank);
        case (rank)
            2'd0:    irq_code = 5'd11;
            2'd1:    irq_code = 5'd3;
            default: irq_code = 5'd7;
        endcase
    endfunction
endpackage

// File: rtl/trap_prio_enc.sv
// Module: generic priority encoder.
// HIGH_FIRST=1 selects the highest set index, 0 the lowest.
// Assumes W >= 2; idx is zero when nothing is set.
module trap_prio_enc #(
    parameter int W          = 8,
    parameter bit HIGH_FIRST = 1'b0,
    localparam int IW        = $clog2(W)
) (
    input  logic [W-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    assign any = |req;

    generate
        if (HIGH_FIRST) begin : g_high
            // Last hit in ascending scan is the highest index
            always_comb begin
                idx = '0;
                for (int i = 0; i < W; i++) begin
                    if (req[i]) idx = IW'(i);
                end
            end
        end else begin : g_low
            // Last hit in descending scan is the lowest index
            always_comb begin
                idx = '0;
                for (int i = W - 1; i >= 0; i--) begin
                    if (req[i]) idx = IW'(i);
                end
            end
        end
    endgenerate
endmodule

// File: rtl/trap_cause_sel.sv
// Module: per-stage exception cause selector.
// Masks the flags with the stage valid bit and picks the highest-ranked slot.
// Assumes slot index order equals priority order.
module trap_cause_sel
    import trap_arb_pkg::*;
(
    input  logic              vld,
    input  logic [NCAUSE-1:0] flags,
    output logic              hit,
    output logic [4:0]        code
);
    logic [NCAUSE-1:0] live;
    logic [2:0]        slot;

    // Gate the flags of an empty stage
    assign live = flags & {NCAUSE{vld}};

    trap_prio_enc #(.W(NCAUSE), .HIGH_FIRST(1'b0)) u_enc (
        .req (live),
        .any (hit),
        .idx (slot)
    );

    assign code = exc_code(slot);
endmodule

// File: rtl/trap_irq_sel.sv
// Module: machine interrupt gate and ranker.
// A source counts when pending, enabled and globally enabled.
// Rank order is external, software, timer.
module trap_irq_sel
    import trap_arb_pkg::*;
(
    input  logic [NIRQ-1:0] pend,
    input  logic [NIRQ-1:0] en,
    input  logic            glb_ie,
    output logic            hit,
    output logic [4:0]      code
);
    logic [NIRQ-1:0] gated;
    logic [NIRQ-1:0] ranked;
    logic [1:0]      rank;

    // Apply the three-way gate
    assign gated  = pend & en & {NIRQ{glb_ie}};
    // Reorder so rank 0 is the most urgent source
    assign ranked = {gated[IRQ_TMR], gated[IRQ_SW], gated[IRQ_EXT]};

    trap_prio_enc #(.W(NIRQ), .HIGH_FIRST(1'b0)) u_enc (
        .req (ranked),
        .any (hit),
        .idx (rank)
    );

    assign code = irq_code(rank);
endmodule

// File: rtl/trap_arbiter.sv
// Module: pipeline trap priority arbiter (top).
// Picks at most one trap per cycle: interrupts first (attached to the oldest
// valid stage), else the oldest valid stage with an exception. Blocks while a
// data access is outstanding and for one cycle after each trap.
// Assumes stage NSTG-1 is the oldest and stage 0 the youngest.
module trap_arbiter
    import trap_arb_pkg::*;
#(
    parameter int NSTG = 4,
    parameter int XLEN = 32,
    localparam int SW  = $clog2(NSTG)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NSTG-1:0]        stg_vld,
    input  logic [NSTG*NCAUSE-1:0] stg_exc,
    input  logic [NSTG*XLEN-1:0]   stg_pc,
    input  logic [NIRQ-1:0]        irq_pend,
    input  logic [NIRQ-1:0]        irq_en,
    input  logic                   glb_ie,
    input  logic                   mem_busy,
    output logic                   trap_valid,
    output logic [XLEN-1:0]        trap_cause,
    output logic [SW-1:0]          trap_stage,
    output logic [XLEN-1:0]        trap_pc,
    output logic [NSTG-1:0]        trap_flush
);
    logic [NSTG-1:0] stg_hit;
    logic [4:0]      code_arr [NSTG];
    logic [XLEN-1:0] pc_arr   [NSTG];

    logic            exc_any, vld_any, irq_hit, accept, go;
    logic [SW-1:0]   exc_stg, old_stg, sel_stg;
    logic [4:0]      irq_cd;
    logic [XLEN-1:0] cause_n;
    logic [NSTG-1:0] flush_n;

    generate
        for (genvar s = 0; s < NSTG; s++) begin : g_stage
            trap_cause_sel u_sel (
                .vld   (stg_vld[s]),
                .flags (stg_exc[s*NCAUSE +: NCAUSE]),
                .hit   (stg_hit[s]),
                .code  (code_arr[s])
            );
            assign pc_arr[s] = stg_pc[s*XLEN +: XLEN];
        end
    endgenerate

    // Oldest stage holding an exception
    trap_prio_enc #(.W(NSTG), .HIGH_FIRST(1'b1)) u_exc_pick (
        .req (stg_hit),
        .any (exc_any),
        .idx (exc_stg)
    );

    // Oldest valid stage, target of an interrupt
    trap_prio_enc #(.W(NSTG), .HIGH_FIRST(1'b1)) u_old_pick (
        .req (stg_vld),
        .any (vld_any),
        .idx (old_stg)
    );

    trap_irq_sel u_irq (
        .pend   (irq_pend),
        .en     (irq_en),
        .glb_ie (glb_ie),
        .hit    (irq_hit),
        .code   (irq_cd)
    );

    // Acceptance window: no bus access in flight, not right after a trap
    assign accept = !mem_busy && !trap_valid;
    assign go     = accept && (irq_hit || exc_any);

    // Choose stage and cause with interrupt precedence
    always_comb begin
        sel_stg = '0;
        cause_n = '0;
        if (irq_hit) begin
            sel_stg = vld_any ? old_stg : '0;
            cause_n = {1'b1, {(XLEN-6){1'b0}}, irq_cd};
        end else if (exc_any) begin
            sel_stg = exc_stg;
            cause_n = {{(XLEN-5){1'b0}}, code_arr[exc_stg]};
        end
    end

    // Flush the chosen stage and every younger one
    always_comb begin
        for (int s = 0; s < NSTG; s++) begin
            flush_n[s] = go && (SW'(s) <= sel_stg);
        end
    end

    // Register the trap outputs, zero when idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_valid <= 1'b0;
            trap_cause <= '0;
            trap_stage <= '0;
            trap_pc    <= '0;
            trap_flush <= '0;
        end else begin
            trap_valid <= go;
            trap_cause <= go ? cause_n : '0;
            trap_stage <= go ? sel_stg : '0;
            trap_pc    <= go ? pc_arr[sel_stg] : '0;
            trap_flush <= flush_n;
        end
    end
endmodule

// File: rtl/trap_arbiter_chk.sv
// Module: assertion checker for trap_arbiter, bound to every instance.
// Assumes inputs are stable around the rising edge.
module trap_arbiter_chk
    import trap_arb_pkg::*;
#(
    parameter int NSTG = 4,
    parameter int XLEN = 32,
    localparam int SW  = $clog2(NSTG)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NSTG-1:0]        stg_vld,
    input logic [NSTG*NCAUSE-1:0] stg_exc,
    input logic [NSTG*XLEN-1:0]   stg_pc,
    input logic [NIRQ-1:0]        irq_pend,
    input logic [NIRQ-1:0]        irq_en,
    input logic                   glb_ie,
    input logic                   mem_busy,
    input logic                   trap_valid,
    input logic [XLEN-1:0]        trap_cause,
    input logic [SW-1:0]          trap_stage,
    input logic [XLEN-1:0]        trap_pc,
    input logic [NSTG-1:0]        trap_flush
);
    logic src_exc;

    // Any exception flag on a valid stage
    always_comb begin
        src_exc = 1'b0;
        for (int s = 0; s < NSTG; s++) begin
            src_exc |= stg_vld[s] && (|stg_exc[s*NCAUSE +: NCAUSE]);
        end
    end

    p_busy_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_busy |=> !trap_valid);

    p_no_back2back_r10: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |=> !trap_valid);

    p_flush_shape_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |-> (trap_flush[0] && ((trap_flush & (trap_flush + 1'b1)) == '0)
                        && ($countones(trap_flush) == int'(trap_stage) + 1)));

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_valid |-> (trap_flush == '0 && trap_cause == '0 && trap_pc == '0));

    p_irq_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!glb_ie && !src_exc) |=> !trap_valid);

    p_no_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_exc && ((irq_pend & irq_en) == '0)) |=> !trap_valid);
endmodule

bind trap_arbiter trap_arbiter_chk #(.NSTG(NSTG), .XLEN(XLEN)) u_chk (.*);

// File: tb/trap_arbiter_bench.sv
// Bench: random plus directed stimulus against a behavioural model.
module trap_arbiter_bench;
    localparam int NSTG = 4;
    localparam int XLEN = 32;
    localparam int NC   = 8;
    localparam int SW   = 2;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic [NSTG-1:0]      stg_vld;
    logic [NSTG*NC-1:0]   stg_exc;
    logic [NSTG*XLEN-1:0] stg_pc;
    logic [2:0]           irq_pend, irq_en;
    logic                 glb_ie, mem_busy;
    logic                 trap_valid;
    logic [XLEN-1:0]      trap_cause, trap_pc;
    logic [SW-1:0]        trap_stage;
    logic [NSTG-1:0]      trap_flush;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;
    bit  prev_v = 1'b0;

    always #10 clk = ~clk;

    trap_arbiter #(.NSTG(NSTG), .XLEN(XLEN)) u_trap_arbiter (.*);

    function automatic logic [4:0] slot_code(int k);
        case (k)
            0: return 5'd2;  1: return 5'd0;  2: return 5'd11; 3: return 5'd3;
            4: return 5'd4;  5: return 5'd5;  6: return 5'd6;  default: return 5'd7;
        endcase
    endfunction

    // Behavioural model of the requirements
    function automatic void model(output logic v, output logic [XLEN-1:0] c,
                                  output logic [SW-1:0] st, output logic [XLEN-1:0] pc,
                                  output logic [NSTG-1:0] fl);
        logic [2:0] g;
        int tgt;
        bit irq, exc;
        v = 0; c = '0; st = '0; pc = '0; fl = '0;
        g = irq_pend & irq_en & {3{glb_ie}};
        irq = |g;
        exc = 0;
        tgt = 0;
        if (irq) begin
            for (int s = 0; s < NSTG; s++) if (stg_vld[s]) tgt = s;
            c = {1'b1, 26'd0, g[2] ? 5'd11 : (g[0] ? 5'd3 : 5'd7)};
        end else begin
            for (int s = 0; s < NSTG; s++)
                if (stg_vld[s] && |stg_exc[s*NC +: NC]) begin
                    tgt = s;
                    exc = 1;
                end
            if (exc)
                for (int k = NC - 1; k >= 0; k--)
                    if (stg_exc[tgt*NC + k]) c = {27'd0, slot_code(k)};
        end
        if ((irq || exc) && !mem_busy && !prev_v) begin
            v  = 1;
            st = SW'(tgt);
            pc = stg_pc[tgt*XLEN +: XLEN];
            for (int s = 0; s < NSTG; s++) fl[s] = (s <= tgt);
        end else begin
            c = '0;
        end
    endfunction

    task automatic clear_in();
        stg_vld = '0; stg_exc = '0; irq_pend = '0; irq_en = '0;
        glb_ie = 0; mem_busy = 0;
    endtask

    // Apply current inputs for one cycle and compare after the edge
    task automatic step(string tag);
        logic ev; logic [XLEN-1:0] ec, ep; logic [SW-1:0] es; logic [NSTG-1:0] ef;
        model(ev, ec, es, ep, ef);
        @(posedge clk);
        #2;
        n_chk++;
        if (trap_valid !== ev || trap_cause !== ec || trap_stage !== es ||
            trap_pc !== ep || trap_flush !== ef) begin
            n_bad++;
            $display("FAIL %s: got v=%0b c=%h s=%0d pc=%h f=%b exp v=%0b c=%h s=%0d pc=%h f=%b",
                     tag, trap_valid, trap_cause, trap_stage, trap_pc, trap_flush,
                     ev, ec, es, ep, ef);
        end
        prev_v = ev;
        @(negedge clk);
    endtask

    task automatic idle();
        clear_in();
        step("R1");
    endtask

    // Watchdog
    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got hang exp finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1357_9bdf));
        clear_in();
        for (int s = 0; s < NSTG; s++) stg_pc[s*XLEN +: XLEN] = 32'h8000_0000 + 32'(s * 16);
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        n_chk++;
        if (trap_valid !== 0 || trap_flush !== '0 || trap_cause !== '0) begin
            n_bad++;
            $display("FAIL R1: got v=%0b f=%b exp v=0 f=0", trap_valid, trap_flush);
        end
        rst_n = 1;
        idle();

        // R2: busy blocks a memory-stage fault and an interrupt
        stg_vld = 4'hF; stg_exc[3*NC + 5] = 1; irq_pend = 3'b111; irq_en = 3'b111;
        glb_ie = 1; mem_busy = 1;
        step("R2");
        idle();

        // R3: each gate off in turn
        stg_vld = 4'hF; irq_pend = 3'b100; irq_en = 3'b100; glb_ie = 0; step("R3"); idle();
        stg_vld = 4'hF; irq_pend = 3'b100; irq_en = 3'b011; glb_ie = 1; step("R3"); idle();
        stg_vld = 4'hF; irq_pend = 3'b011; irq_en = 3'b100; glb_ie = 1; step("R3"); idle();

        // R4: ranking ext > sw > timer
        stg_vld = 4'hF; irq_pend = 3'b111; irq_en = 3'b111; glb_ie = 1; step("R4"); idle();
        stg_vld = 4'hF; irq_pend = 3'b011; irq_en = 3'b111; glb_ie = 1; step("R4"); idle();
        stg_vld = 4'hF; irq_pend = 3'b010; irq_en = 3'b111; glb_ie = 1; step("R4"); idle();

        // R5: interrupt beats a memory fault; attaches to oldest valid stage
        stg_vld = 4'hF; stg_exc[3*NC + 7] = 1; irq_pend = 3'b010; irq_en = 3'b010;
        glb_ie = 1; step("R5"); idle();
        stg_vld = 4'b0011; stg_exc[0*NC + 3] = 1; irq_pend = 3'b001; irq_en = 3'b001;
        glb_ie = 1; step("R5"); idle();
        irq_pend = 3'b001; irq_en = 3'b001; glb_ie = 1; step("R5"); idle();

        // R6: older ecall in execute beats fetch breakpoint
        stg_vld = 4'hF; stg_exc[0*NC + 3] = 1; stg_exc[2*NC + 2] = 1; step("R6"); idle();
        stg_vld = 4'hF; stg_exc[1*NC + 0] = 1; stg_exc[3*NC + 4] = 1; step("R6"); idle();

        // R7: within-stage order walk
        for (int k = 0; k < NC; k++) begin
            stg_vld = 4'b0100;
            for (int j = k; j < NC; j++) stg_exc[2*NC + j] = 1;
            step("R7");
            idle();
        end

        // R9: flags of an empty stage are ignored
        stg_vld = 4'b0011; stg_exc[3*NC + 5] = 1; stg_exc[2*NC + 2] = 1; step("R9"); idle();
        stg_vld = 4'b0110; stg_exc[3*NC + 0] = 1; stg_exc[1*NC + 1] = 1; step("R9"); idle();

        // R10: persistent source pulses every other cycle
        stg_vld = 4'hF; stg_exc[1*NC + 0] = 1;
        step("R10"); step("R10"); step("R10");
        idle();

        // R8 and all: constrained random
        for (int n = 0; n < 3000; n++) begin
            stg_vld = 4'($urandom);
            for (int s = 0; s < NSTG; s++) begin
                stg_exc[s*NC +: NC] = ($urandom_range(2) == 0) ?
                    (8'($urandom) & 8'($urandom) & 8'($urandom)) : 8'h00;
                stg_pc[s*XLEN +: XLEN] = {$urandom} & 32'hFFFF_FFFC;
            end
            irq_pend = ($urandom_range(3) == 0) ? 3'($urandom) : 3'b000;
            irq_en   = 3'($urandom);
            glb_ie   = 1'($urandom);
            mem_busy = ($urandom_range(4) == 0);
            step("R8");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule